// File: doc/BRIEF.md
# Multi-Channel Tick Timer

This peripheral holds three reloadable down-counters and one free-running up-counter, all reached through a small word-addressed register bus. Two down-counters are 16 bits wide and the third is 32 bits wide. Each one decrements on a selected tick strobe and raises its own interrupt line when it counts past zero. In periodic mode it then restarts from its load value. In free-run mode it wraps to all ones. The fourth counter is 40 bits wide and advances on the fast tick strobe while its enable bit is set. It never interrupts, and software reads its low 32 bits as a timestamp that only moves forward.

Two single-cycle strobe inputs stand for the two count rates. `slow_tick` stands for the roughly 508 kHz rate and `fast_tick` for the 983.04 kHz rate. Register writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Address map (word addresses). Down-counter *c* (0 to 2) sits at 4*c: +0 load, +1 live value, +2 control, +3 interrupt clear. Address 12 is the low word of the 40-bit counter and address 13 its high word. All other addresses read zero.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every register reads 0 and all three interrupt lines are low.
- R2: A control write keeps only bit 7 (enable), bit 6 (periodic) and bit 3 (tick select). The other control bits read back as 0.
- R3: An enabled down-counter decrements by one on each cycle where its selected strobe is high. Control bit 3 = 1 selects `slow_tick` and 0 selects `fast_tick`. A stopped counter ignores both strobes.
- R4: In periodic mode a tick at count 0 reloads the load register. A load value of N-1 therefore gives an underflow every N ticks. A load written while running is used at the next reload.
- R5: In free-run mode (bit 6 = 0) a tick at count 0 wraps the count to the all-ones value of that counter's width.
- R6: An underflow sets the counter's interrupt line on the next edge. It stays set until any write to that counter's clear address. If an underflow and a clear write fall in the same cycle, the line stays set.
- R7: Writing the load register while the counter is stopped also sets the live count. Writing it while running leaves the live count unchanged.
- R8: Counters 0 and 1 keep only bits 15:0 of a load write. Counter 2 keeps all 32 bits. Value reads are zero-extended.
- R9: The 40-bit counter increments on each `fast_tick` cycle while enabled and ignores `slow_tick`. Bit 8 of a high-word write sets or clears the enable and leaves the count unchanged. The high word reads count bits 39:32 in bits 7:0 and the enable in bit 8. The low word reads count bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow count strobe |
| fast_tick | input | 1 | Fast count strobe |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 3 | Interrupt line per down-counter |

## Verification
Most internal faults in this block show up at the ports within one tick. A mistaken decrement or reload shows in the live value read on the cycle after the tick. A wrong control mask shows on the first control read-back. A lost or spurious interrupt set or clear shows on `irq` one edge after the underflow or the clear write. The same-cycle collision of clear and underflow is driven on purpose, because the wrong priority would silently drop an interrupt. The 40-bit counter's enable and its read-back packing are checked by mixing strobe types and high-word writes whose other bits are set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int N_CH   = 3;

  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_SLOW = 3;
  localparam logic [7:0] CTL_KEEP = 8'hC8;

  localparam logic [1:0] RG_LOAD  = 2'd0;
  localparam logic [1:0] RG_VALUE = 2'd1;
  localparam logic [1:0] RG_CTRL  = 2'd2;
  localparam logic [1:0] RG_CLEAR = 2'd3;

  localparam logic [ADDR_W-1:0] AD_FREE_LO = 4'd12;
  localparam logic [ADDR_W-1:0] AD_FREE_HI = 4'd13;
  localparam int FREE_EN_BIT = 8;

  // Next count of a down-counter on a tick, width given by mask.
  function automatic logic [31:0] next_down(input logic [31:0] cur,
                                            input logic [31:0] reload,
                                            input logic        periodic,
                                            input logic [31:0] mask);
    if (cur == 32'd0) return periodic ? (reload & mask) : mask;
    return (cur - 32'd1) & mask;
  endfunction
endpackage

// File: rtl/tmr_down_chan.sv
module tmr_down_chan
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic             load_wr,
  input  logic             ctrl_wr,
  input  logic             clear_wr,
  input  logic [WIDTH-1:0] wload,
  input  logic [7:0]       wctrl,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] load_val,
  output logic [7:0]       ctrl,
  output logic             tick_ev,
  output logic             uflow_ev,
  output logic             irq
);
  localparam logic [31:0] MASK = 32'((64'd1 << WIDTH) - 64'd1);

  logic [31:0] nxt;

  assign tick_ev  = ctrl[CTL_EN] & (ctrl[CTL_SLOW] ? slow_tick : fast_tick);
  assign uflow_ev = tick_ev & (count == '0);
  assign nxt      = next_down(32'(count), 32'(load_val), ctrl[CTL_PER], MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      load_val <= '0;
      count    <= '0;
      irq      <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= wctrl & CTL_KEEP;
      if (load_wr) load_val <= wload;
      if (load_wr && !ctrl[CTL_EN]) count <= wload;
      else if (tick_ev)             count <= nxt[WIDTH-1:0];
      if (uflow_ev)      irq <= 1'b1;
      else if (clear_wr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr #(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             hi_wr,
  input  logic             en_in,
  output logic [WIDTH-1:0] count,
  output logic             en,
  output logic             inc_ev
);
  assign inc_ev = en & fast_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      en    <= 1'b0;
    end else begin
      if (hi_wr)  en <= en_in;
      if (inc_ev) count <= count + WIDTH'(1);
    end
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        fast_tick,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [2:0]  irq
);
  localparam int HI_W = FREE_W - 32;

  logic [N_CH-1:0]             load_wr, ctrl_wr, clear_wr;
  logic [N_CH-1:0]             tick_ev, uflow_ev, ctrl_en, ctrl_per;
  logic [N_CH-1:0][31:0]       cnt_ext, load_ext;
  logic [N_CH-1:0][7:0]        ctrl_all;
  logic [FREE_W-1:0]           free_cnt;
  logic                        free_en, free_inc, free_hi_wr;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int CW = (g == N_CH - 1) ? WIDE_W : NARROW_W;
    logic          sel;
    logic [CW-1:0] c_cnt, c_load;
    logic [7:0]    c_ctrl;

    assign sel         = bus_wr && (bus_addr[3:2] == 2'(g));
    assign load_wr[g]  = sel && (bus_addr[1:0] == RG_LOAD);
    assign ctrl_wr[g]  = sel && (bus_addr[1:0] == RG_CTRL);
    assign clear_wr[g] = sel && (bus_addr[1:0] == RG_CLEAR);

    tmr_down_chan #(.WIDTH(CW)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_tick(slow_tick),
      .fast_tick(fast_tick),
      .load_wr  (load_wr[g]),
      .ctrl_wr  (ctrl_wr[g]),
      .clear_wr (clear_wr[g]),
      .wload    (bus_wdata[CW-1:0]),
      .wctrl    (bus_wdata[7:0]),
      .count    (c_cnt),
      .load_val (c_load),
      .ctrl     (c_ctrl),
      .tick_ev  (tick_ev[g]),
      .uflow_ev (uflow_ev[g]),
      .irq      (irq[g])
    );

    assign cnt_ext[g]  = 32'(c_cnt);
    assign load_ext[g] = 32'(c_load);
    assign ctrl_all[g] = c_ctrl;
    assign ctrl_en[g]  = c_ctrl[CTL_EN];
    assign ctrl_per[g] = c_ctrl[CTL_PER];
  end

  assign free_hi_wr = bus_wr && (bus_addr == AD_FREE_HI);

  tmr_free_ctr #(.WIDTH(FREE_W)) free_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_tick(fast_tick),
    .hi_wr    (free_hi_wr),
    .en_in    (bus_wdata[FREE_EN_BIT]),
    .count    (free_cnt),
    .en       (free_en),
    .inc_ev   (free_inc)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3:2] < 2'(N_CH)) begin
      case (bus_addr[1:0])
        RG_LOAD:  bus_rdata = load_ext[bus_addr[3:2]];
        RG_VALUE: bus_rdata = cnt_ext[bus_addr[3:2]];
        RG_CTRL:  bus_rdata = 32'(ctrl_all[bus_addr[3:2]]);
        default:  bus_rdata = '0;
      endcase
    end else if (bus_addr == AD_FREE_LO) begin
      bus_rdata = free_cnt[31:0];
    end else if (bus_addr == AD_FREE_HI) begin
      bus_rdata[HI_W-1:0]   = free_cnt[FREE_W-1:32];
      bus_rdata[FREE_EN_BIT] = free_en;
    end
  end
endmodule

// File: rtl/tick_timer_unit_chk.sv
module tick_timer_unit_chk
  import tmr_pkg::*;
#(
  parameter int FREE_W = 40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CH-1:0]       irq,
  input logic [N_CH-1:0]       tick_ev,
  input logic [N_CH-1:0]       uflow_ev,
  input logic [N_CH-1:0]       clear_wr,
  input logic [N_CH-1:0]       load_wr,
  input logic [N_CH-1:0]       ctrl_en,
  input logic [N_CH-1:0]       ctrl_per,
  input logic [N_CH-1:0][31:0] cnt_ext,
  input logic [N_CH-1:0][31:0] load_ext,
  input logic [FREE_W-1:0]     free_cnt,
  input logic                  free_inc
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(uflow_ev[i]));
    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uflow_ev[i] |=> irq[i]);
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_wr[i] && !uflow_ev[i]) |=> !irq[i]);
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en[i] && !load_wr[i]) |=> $stable(cnt_ext[i]));
    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_ev[i] && cnt_ext[i] != 32'd0) |=> cnt_ext[i] == $past(cnt_ext[i]) - 32'd1);
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow_ev[i] && ctrl_per[i]) |=> cnt_ext[i] == $past(load_ext[i]));
  end

  assert_free_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_inc |=> free_cnt == $past(free_cnt) + FREE_W'(1));
  assert_free_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !free_inc |=> $stable(free_cnt));
endmodule

bind tick_timer_unit tick_timer_unit_chk #(.FREE_W(FREE_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .tick_ev (tick_ev),
  .uflow_ev(uflow_ev),
  .clear_wr(clear_wr),
  .load_wr (load_wr),
  .ctrl_en (ctrl_en),
  .ctrl_per(ctrl_per),
  .cnt_ext (cnt_ext),
  .load_ext(load_ext),
  .free_cnt(free_cnt),
  .free_inc(free_inc)
);

// File: tb/tick_timer_unit_tb_top.sv
`timescale 1ns/1ps
module tick_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, fast_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tick_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // vector table: channel, load value, number of slow ticks
  localparam int VEC_N = 6;
  localparam int VEC_CH   [VEC_N] = '{0, 0, 1, 1, 2, 2};
  localparam int VEC_LOAD [VEC_N] = '{9, 9, 3, 0, 70000, 5};
  localparam int VEC_TICKS[VEC_N] = '{4, 10, 9, 5, 20, 17};

  function automatic logic [3:0] ad(int ch, int r);
    return 4'(ch * 4 + r);
  endfunction

  // periodic countdown: period is load+1 ticks
  function automatic logic [31:0] exp_periodic(longint l, longint n);
    return 32'(l - (n % (l + 1)));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pulse(bit slow, int n);
    if (n > 0) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reg %0d", a), v, 32'd0);
    end
    check("R1 irq", 32'(irq), 32'd0);

    // vector table walk: R3/R4/R6 with periodic slow-tick counting
    for (int k = 0; k < VEC_N; k++) begin
      wr(ad(VEC_CH[k], 2), 32'h48);
      wr(ad(VEC_CH[k], 3), 32'd0);
      wr(ad(VEC_CH[k], 0), 32'(VEC_LOAD[k]));
      wr(ad(VEC_CH[k], 2), 32'hC8);
      pulse(1'b1, VEC_TICKS[k]);
      rd(ad(VEC_CH[k], 1), v);
      check($sformatf("R4 vec %0d value", k), v,
            exp_periodic(longint'(VEC_LOAD[k]), longint'(VEC_TICKS[k])));
      check($sformatf("R6 vec %0d irq", k), 32'(irq[VEC_CH[k]]),
            32'(VEC_TICKS[k] > VEC_LOAD[k]));
      wr(ad(VEC_CH[k], 2), 32'h48);
    end

    // R2: control mask
    wr(ad(1, 2), 32'hFFFF_FFFF);
    rd(ad(1, 2), v);
    check("R2 ctrl mask", v, 32'h0000_00C8);
    wr(ad(1, 2), 32'h0);

    // R3: tick select and stopped counter
    wr(ad(2, 2), 32'h40);
    wr(ad(2, 0), 32'd100);
    wr(ad(2, 2), 32'hC0);
    pulse(1'b1, 5);
    rd(ad(2, 1), v);
    check("R3 slow ignored when fast selected", v, 32'd100);
    pulse(1'b0, 7);
    rd(ad(2, 1), v);
    check("R3 fast decrements", v, 32'd93);
    wr(ad(2, 2), 32'h40);
    pulse(1'b0, 3);
    rd(ad(2, 1), v);
    check("R3 stopped holds", v, 32'd93);

    // R7 and R4: load while running
    wr(ad(0, 2), 32'h48);
    wr(ad(0, 0), 32'd20);
    wr(ad(0, 2), 32'hC8);
    pulse(1'b1, 3);
    wr(ad(0, 0), 32'd5);
    rd(ad(0, 1), v);
    check("R7 running load keeps count", v, 32'd17);
    pulse(1'b1, 18);
    rd(ad(0, 1), v);
    check("R4 new load used at reload", v, 32'd5);

    // R5: free-run wrap per width
    wr(ad(1, 2), 32'h08);
    wr(ad(1, 0), 32'd1);
    wr(ad(1, 2), 32'h88);
    pulse(1'b1, 2);
    rd(ad(1, 1), v);
    check("R5 16-bit wrap", v, 32'h0000_FFFF);
    pulse(1'b1, 1);
    rd(ad(1, 1), v);
    check("R5 after wrap", v, 32'h0000_FFFE);
    wr(ad(1, 2), 32'h0);
    wr(ad(2, 2), 32'h08);
    wr(ad(2, 0), 32'd1);
    wr(ad(2, 2), 32'h88);
    pulse(1'b1, 2);
    rd(ad(2, 1), v);
    check("R5 32-bit wrap", v, 32'hFFFF_FFFF);
    wr(ad(2, 2), 32'h0);

    // R6: clear colliding with underflow, then plain clear
    wr(ad(0, 2), 32'h48);
    wr(ad(0, 3), 32'd0);
    wr(ad(0, 0), 32'd2);
    wr(ad(0, 2), 32'hC8);
    pulse(1'b1, 3);
    check("R6 irq after underflow", 32'(irq[0]), 32'd1);
    pulse(1'b1, 2);
    @(negedge clk);
    slow_tick = 1'b1; bus_wr = 1'b1; bus_addr = ad(0, 3); bus_wdata = 32'd0;
    @(negedge clk);
    slow_tick = 1'b0; bus_wr = 1'b0;
    #1 check("R6 underflow beats clear", 32'(irq[0]), 32'd1);
    wr(ad(0, 2), 32'h48);
    wr(ad(0, 3), 32'd0);
    #1 check("R6 clear drops irq", 32'(irq[0]), 32'd0);

    // R8: width truncation
    wr(ad(0, 0), 32'h0001_2345);
    rd(ad(0, 1), v);
    check("R8 16-bit value", v, 32'h0000_2345);
    rd(ad(0, 0), v);
    check("R8 16-bit load", v, 32'h0000_2345);
    wr(ad(2, 0), 32'hDEAD_BEEF);
    rd(ad(2, 1), v);
    check("R8 32-bit value", v, 32'hDEAD_BEEF);

    // R9: 40-bit counter
    wr(4'd13, 32'h100);
    rd(4'd13, v);
    check("R9 enable readback", v, 32'h100);
    pulse(1'b0, 6);
    rd(4'd12, v);
    check("R9 fast count", v, 32'd6);
    pulse(1'b1, 4);
    rd(4'd12, v);
    check("R9 slow ignored", v, 32'd6);
    wr(4'd13, 32'h0);
    pulse(1'b0, 3);
    rd(4'd12, v);
    check("R9 disabled holds", v, 32'd6);
    rd(4'd13, v);
    check("R9 high word disabled", v, 32'h0);
    wr(4'd13, 32'h1FF);
    pulse(1'b0, 2);
    rd(4'd12, v);
    check("R9 resumes", v, 32'd8);
    rd(4'd13, v);
    check("R9 high word packing", v, 32'h100);

    finish_run();
  end
endmodule